// File: doc/BRIEF.md
# Power-Good Window Monitor

This block produces the power-good status of a regulated supply rail. Each clock it takes a digitized feedback code and compares it with percentage windows of a reference code. There are two windows. A narrow inner window decides when the rail may be called good. A wider outer window decides when the rail must be called bad. Between the two windows lies a hysteresis band, and in that band the current status is kept.

Each direction has its own qualification timer. Going good uses a long one, and going bad uses a short one. Each timer runs only while its condition holds without a break, and it restarts from zero when the condition drops out.

Three supply faults bypass both timers and force not-good at the next clock edge: input undervoltage, enable low, and thermal shutdown. The status is driven on two outputs. One is an active-low pull-down request, which models an open-drain pin. The other is a plain good flag.

Top module: `pgood_monitor`

## Requirements
- R1: The status may become good only on cycles where `ss_done` is 1 and `100*fb_code` lies inclusively within `[IN_LO_PCT*ref_code, IN_HI_PCT*ref_code]` (92 % and 108 % by default).
- R2: From not-good, the good condition must hold on `GOOD_CYCLES` consecutive sampling edges. `good_o` rises on the edge that samples the last of these cycles.
- R3: From good, the bad condition (`100*fb_code < OUT_LO_PCT*ref_code` or `100*fb_code > OUT_HI_PCT*ref_code`, 84 % and 116 % by default) must hold on `BAD_CYCLES` consecutive edges. `good_o` falls on the edge that samples the last of these cycles.
- R4: The window edges are exact. A code of exactly 92 % or 108 % of the reference qualifies as good. A code of exactly 84 % or 116 % does not count as bad.
- R5: When `vin_uv` is 1, `en` is 0 or `ot_shdn` is 1, the status is not-good after the first edge that samples that input, whatever the timers hold.
- R6: `pd_n_o` is 0 (pulling low) while not-good and 1 (released) while good. `good_o` is 1 exactly when good.
- R7: While the feedback sits in the hysteresis band, or is in the inner window with `ss_done` at 0, the status stays as it is for any length of time.
- R8: While `rst` is 1, the status is not-good and both timers are cleared. After `rst` falls, the first good transition needs the full `GOOD_CYCLES`.
- R9: An active fault clears both timers. After the fault clears, going good again needs the full `GOOD_CYCLES`.
- R10: A break of even one cycle in a good or bad condition restarts that condition's timer from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_code | input | DW | Sampled feedback code |
| ref_code | input | DW | Reference code |
| ss_done | input | 1 | Soft start completed |
| vin_uv | input | 1 | Input undervoltage fault, active high |
| en | input | 1 | Enable, low forces not-good |
| ot_shdn | input | 1 | Thermal shutdown, active high |
| pd_n_o | output | 1 | Pull-down request, 0 pulls the pin low |
| good_o | output | 1 | Power-good flag |

## Verification
A timer that is not cleared when its condition breaks shows up at the ports as an early transition. The status flips before the full count of uninterrupted cycles, and the test pins this to the exact edge. A window comparison off by one code shows up as a wrong status within one qualification period at the boundary codes that are exercised. A fault path that goes through a timer leaves the flag high one edge after the fault input, which is where the check samples.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    PG_LOW  = 1'b0,
    PG_HIGH = 1'b1
  } pg_state_e;

  typedef struct packed {
    logic inner;  // inside the qualifying window
    logic outer;  // outside the tolerated window
  } pg_win_t;
endpackage

// File: rtl/pg_window.sv
module pg_window
  import pg_pkg::*;
#(
  parameter int DW         = 12,
  parameter int IN_LO_PCT  = 92,
  parameter int IN_HI_PCT  = 108,
  parameter int OUT_LO_PCT = 84,
  parameter int OUT_HI_PCT = 116
) (
  input  logic [DW-1:0] fb_code,
  input  logic [DW-1:0] ref_code,
  output pg_win_t       win
);
  // Cross-multiplied compares are exact: no division, no rounding error.
  localparam int PW = DW + 8;

  logic [PW-1:0] fb_x100;
  logic [PW-1:0] in_lo, in_hi, out_lo, out_hi;

  always_comb begin
    fb_x100 = PW'(fb_code) * PW'(100);
    in_lo   = PW'(ref_code) * PW'(IN_LO_PCT);
    in_hi   = PW'(ref_code) * PW'(IN_HI_PCT);
    out_lo  = PW'(ref_code) * PW'(OUT_LO_PCT);
    out_hi  = PW'(ref_code) * PW'(OUT_HI_PCT);
    win.inner = (fb_x100 >= in_lo) && (fb_x100 <= in_hi);
    win.outer = (fb_x100 < out_lo) || (fb_x100 > out_hi);
  end
endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !run || done) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor
  import pg_pkg::*;
#(
  parameter int DW          = 12,
  parameter int GOOD_CYCLES = 64000,  // 256 us at 250 MHz
  parameter int BAD_CYCLES  = 2000,   // 8 us at 250 MHz
  parameter int IN_LO_PCT   = 92,
  parameter int IN_HI_PCT   = 108,
  parameter int OUT_LO_PCT  = 84,
  parameter int OUT_HI_PCT  = 116
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] fb_code,
  input  logic [DW-1:0] ref_code,
  input  logic          ss_done,
  input  logic          vin_uv,
  input  logic          en,
  input  logic          ot_shdn,
  output logic          pd_n_o,
  output logic          good_o
);
  pg_win_t   win;
  pg_state_e state;
  logic      in_win, out_fault, fault;
  logic      good_run, bad_run, good_done, bad_done;

  pg_window #(
    .DW(DW), .IN_LO_PCT(IN_LO_PCT), .IN_HI_PCT(IN_HI_PCT),
    .OUT_LO_PCT(OUT_LO_PCT), .OUT_HI_PCT(OUT_HI_PCT)
  ) u_win (
    .fb_code (fb_code),
    .ref_code(ref_code),
    .win     (win)
  );

  assign in_win    = win.inner;
  assign out_fault = win.outer;
  assign fault     = vin_uv || !en || ot_shdn;

  // Each timer runs only while its own condition holds in the matching state.
  assign good_run = (state == PG_LOW)  && in_win && ss_done && !fault;
  assign bad_run  = (state == PG_HIGH) && out_fault && !fault;

  pg_qual_timer #(.LEN(GOOD_CYCLES)) u_good_tmr (
    .clk(clk), .rst(rst), .clr(fault), .run(good_run), .done(good_done)
  );

  pg_qual_timer #(.LEN(BAD_CYCLES)) u_bad_tmr (
    .clk(clk), .rst(rst), .clr(fault), .run(bad_run), .done(bad_done)
  );

  always_ff @(posedge clk) begin
    if (rst || fault)   state <= PG_LOW;
    else if (good_done) state <= PG_HIGH;
    else if (bad_done)  state <= PG_LOW;
  end

  assign good_o = (state == PG_HIGH);
  assign pd_n_o = (state == PG_HIGH);
endmodule

// File: rtl/pgood_monitor_chk.sv
module pgood_monitor_chk #(
  parameter int GOOD_CYCLES = 64000,
  parameter int BAD_CYCLES  = 2000
) (
  input logic clk,
  input logic rst,
  input logic in_win,
  input logic out_fault,
  input logic ss_done,
  input logic vin_uv,
  input logic en,
  input logic ot_shdn,
  input logic good_o,
  input logic pd_n_o
);
  localparam int MX = (GOOD_CYCLES > BAD_CYCLES) ? GOOD_CYCLES : BAD_CYCLES;
  localparam int SW = $clog2(MX + 1) + 1;

  logic          flt, qual;
  logic [SW-1:0] q_run, b_run;

  assign flt  = vin_uv || !en || ot_shdn;
  assign qual = in_win && ss_done && !flt;

  // Saturating counts of consecutive qualifying / disqualifying samples.
  always_ff @(posedge clk) begin
    if (rst || !qual) q_run <= '0;
    else if (q_run < SW'(MX)) q_run <= q_run + 1'b1;
    if (rst || !out_fault || flt) b_run <= '0;
    else if (b_run < SW'(MX)) b_run <= b_run + 1'b1;
  end

  p_rise_in_window_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(good_o) |-> $past(qual));

  p_rise_after_full_count_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(good_o) |-> (q_run >= SW'(GOOD_CYCLES)));

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(good_o) |-> $past(flt || out_fault));

  p_fall_after_full_count_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(good_o) && !$past(flt)) |-> (b_run >= SW'(BAD_CYCLES)));

  p_fault_forces_low_r5: assert property (@(posedge clk) disable iff (rst)
    flt |=> !good_o);

  p_pin_polarity_r6: assert property (@(posedge clk) disable iff (rst)
    pd_n_o == good_o);

  p_band_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!flt && !out_fault && !(in_win && ss_done)) |=> $stable(good_o));
endmodule

bind pgood_monitor pgood_monitor_chk #(
  .GOOD_CYCLES(GOOD_CYCLES), .BAD_CYCLES(BAD_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .in_win(in_win), .out_fault(out_fault),
  .ss_done(ss_done), .vin_uv(vin_uv), .en(en), .ot_shdn(ot_shdn),
  .good_o(good_o), .pd_n_o(pd_n_o)
);

// File: tb/test_pgood_monitor.sv
`timescale 1ns/1ps
module test_pgood_monitor;
  localparam int DW   = 10;
  localparam int GOOD = 16;
  localparam int BAD  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] fb_code = '0;
  logic [DW-1:0] ref_code = 10'd500;
  logic          ss_done = 1'b0, vin_uv = 1'b0, en = 1'b1, ot_shdn = 1'b0;
  logic          pd_n_o, good_o;
  int            n_chk = 0, n_fail = 0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pgood_monitor #(.DW(DW), .GOOD_CYCLES(GOOD), .BAD_CYCLES(BAD)) i_pgood_monitor (
    .clk(clk), .rst(rst), .fb_code(fb_code), .ref_code(ref_code),
    .ss_done(ss_done), .vin_uv(vin_uv), .en(en), .ot_shdn(ot_shdn),
    .pd_n_o(pd_n_o), .good_o(good_o)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic exp);
    n_chk++;
    if (good_o !== exp || pd_n_o !== exp) begin
      n_fail++;
      $display("FAIL %s: good_o=%b pd_n_o=%b expected both %b at %0t",
               req, good_o, pd_n_o, exp, $time);
    end
  endtask

  task automatic force_low();
    vin_uv = 1'b1; tick(1); vin_uv = 1'b0;
  endtask

  task automatic go_good();
    force_low();
    fb_code = 10'd500; ss_done = 1'b1;
    tick(GOOD);
  endtask

  task automatic t_reset();
    fb_code = 10'd500; ss_done = 1'b1;
    tick(3);
    chk("R8 in reset", 1'b0);
    rst = 1'b0;
    tick(GOOD - 1);
    chk("R8 one short of full count after reset", 1'b0);
    tick(1);
    chk("R2 rise on last qualifying edge", 1'b1);
    chk("R6 pin released when good", 1'b1);
  endtask

  task automatic t_ss_gate();
    force_low();
    ss_done = 1'b0; fb_code = 10'd500;
    tick(3 * GOOD);
    chk("R1 no good before soft start done", 1'b0);
    chk("R7 hold low with soft start pending", 1'b0);
    ss_done = 1'b1;
    tick(GOOD);
    chk("R1 good once soft start done", 1'b1);
  endtask

  task automatic t_good_restart();
    force_low();
    fb_code = 10'd500; ss_done = 1'b1;
    tick(GOOD - 2);
    fb_code = 10'd450; tick(1);
    fb_code = 10'd500; tick(GOOD - 1);
    chk("R10 good timer restarted", 1'b0);
    tick(1);
    chk("R10 good after full restart count", 1'b1);
  endtask

  task automatic t_inner_edges();
    force_low(); fb_code = 10'd460; tick(GOOD);
    chk("R4 exactly 92 pct qualifies", 1'b1);
    force_low(); fb_code = 10'd540; tick(GOOD);
    chk("R4 exactly 108 pct qualifies", 1'b1);
    force_low(); fb_code = 10'd459; tick(2 * GOOD);
    chk("R4 below 92 pct does not qualify", 1'b0);
    fb_code = 10'd541; tick(2 * GOOD);
    chk("R4 above 108 pct does not qualify", 1'b0);
  endtask

  task automatic t_bad_qualify();
    go_good();
    fb_code = 10'd419; tick(BAD - 1);
    chk("R3 still good one short of bad count", 1'b1);
    tick(1);
    chk("R3 low below 84 pct after full count", 1'b0);
    chk("R6 pin pulled low when not good", 1'b0);
    go_good();
    fb_code = 10'd581; tick(BAD);
    chk("R3 low above 116 pct after full count", 1'b0);
  endtask

  task automatic t_band_hold();
    go_good();
    fb_code = 10'd420; tick(3 * BAD + 5);
    chk("R4 exactly 84 pct is not bad", 1'b1);
    fb_code = 10'd580; tick(3 * BAD + 5);
    chk("R4 exactly 116 pct is not bad", 1'b1);
    fb_code = 10'd450; tick(3 * GOOD);
    chk("R7 good held in lower band", 1'b1);
    force_low();
    fb_code = 10'd560; tick(3 * GOOD);
    chk("R7 not-good held in upper band", 1'b0);
  endtask

  task automatic t_bad_restart();
    go_good();
    fb_code = 10'd419; tick(BAD - 1);
    fb_code = 10'd500; tick(1);
    fb_code = 10'd419; tick(BAD - 1);
    chk("R10 bad timer restarted", 1'b1);
    tick(1);
    chk("R10 low after full restart count", 1'b0);
  endtask

  task automatic t_faults();
    go_good(); vin_uv = 1'b1; tick(1);
    chk("R5 undervoltage drops at once", 1'b0);
    vin_uv = 1'b0;
    go_good(); en = 1'b0; tick(1);
    chk("R5 enable low drops at once", 1'b0);
    tick(2 * GOOD);
    chk("R5 held low while enable low", 1'b0);
    en = 1'b1;
    go_good(); ot_shdn = 1'b1; tick(1);
    chk("R5 thermal shutdown drops at once", 1'b0);
    ot_shdn = 1'b0;
    force_low();
    fb_code = 10'd500; ss_done = 1'b1; tick(GOOD - 2);
    en = 1'b0; tick(1); en = 1'b1;
    tick(GOOD - 1);
    chk("R9 timer cleared by fault", 1'b0);
    tick(1);
    chk("R9 good after full count post fault", 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ss_gate();
    t_good_restart();
    t_inner_edges();
    t_bad_qualify();
    t_band_hold();
    t_bad_restart();
    t_faults();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule